// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block adds or subtracts two operands and derives the full set of arithmetic status flags from the outcome. The flags are the nibble (auxiliary) carry, the carry, the signed overflow, the sign, the even parity and the zero flag. It also derives a 2-bit condition code that sorts the outcome into one of four classes: zero, negative, positive or overflow. By default the result, the flags and the code are registered. A parameter can make them purely combinational instead.

Alongside the datapath sits an 8-bit flag register. A load enable captures the freshly computed status flags into the register. A direct-write port overwrites the whole register, which includes two control bits that software sets and that arithmetic never changes. A processor core would use the block as its add/subtract unit and as its condition store.

Top module: `arith_flag_gen`

## Requirements
- R1: With `sub_i`=0, `res_o` equals (`a_i` + `b_i` + `carry_i`) mod 256. Status bit 0 (carry) is 1 when that sum exceeds 255.
- R2: With `sub_i`=1, `res_o` equals (`a_i` - `b_i`) mod 256 and `carry_i` has no effect. Status bit 0 is 1 when no borrow occurs, that is when `a_i` >= `b_i` unsigned.
- R3: Status bit 2 (nibble carry) is 1 when the low four bits of `a_i`, of the effective second operand (`b_i`, or its complement when subtracting) and of the effective carry-in (`carry_i` when adding, 1 when subtracting) sum to more than 15.
- R4: Status bit 5 (overflow) is 1 when the exact signed result of the operation lies outside -128..127.
- R5: Status bit 4 (sign) equals bit 7 of the result.
- R6: Status bit 1 (parity) is 1 when the result holds an even number of one bits.
- R7: Status bit 3 (zero) is 1 when the result is 0.
- R8: `cc_o` is 11 on overflow. Otherwise it is 00 for a zero result, 01 for a negative result and 10 for a positive result. Overflow outranks the zero and sign cases.
- R9: With the default registered output, `res_o`, `st_o` and `cc_o` show the operation that was presented one clock edge earlier.
- R10: When `ld_en_i`=1 and `wr_en_i`=0, the flag register's bits 5:0 take the status of the current inputs at the next edge, in the `st_o` bit layout, and bits 7:6 keep their value. When neither enable is set, the register holds.
- R11: When `wr_en_i`=1, the flag register takes `wr_data_i` at the next edge. This write outranks `ld_en_i`.
- R12: While reset is held, `res_o`=0, `st_o`=6'b001010 (zero and parity set), `cc_o`=00 and `freg_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| carry_i | input | 1 | Carry-in for addition |
| sub_i | input | 1 | 1 selects subtraction |
| ld_en_i | input | 1 | Load computed status into flag register |
| wr_en_i | input | 1 | Direct write of flag register |
| wr_data_i | input | 8 | Data for direct write |
| res_o | output | 8 | Result |
| st_o | output | 6 | Status: {V,S,Z,AC,P,C} |
| cc_o | output | 2 | Condition code |
| freg_o | output | 8 | Flag register |

## Verification
A wrong carry chain inside the block shows up in the carry, nibble carry or overflow bit one cycle after the operands are applied. It often shows up in no other output. The bench therefore compares every flag on its own against an independent integer model. The vectors include the boundary cases 0x7F+1, 0x80+0x80, 0xFF+1, equal-operand subtraction and borrow. A corrupted flag register becomes visible at `freg_o` at the edge after a load or a write. Holds are checked by changing the operands while both enables stay low.

// File: rtl/arith_flag_gen.sv
module arith_flag_gen #(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  input  logic         sub_i,
  input  logic         ld_en_i,
  input  logic         wr_en_i,
  input  logic [7:0]   wr_data_i,
  output logic [W-1:0] res_o,
  output logic [5:0]   st_o,
  output logic [1:0]   cc_o,
  output logic [7:0]   freg_o
);
  localparam int NIB = 4;
  localparam logic [5:0] ST_RST = 6'b001010;

  logic [W-1:0] b_eff;
  logic         ci;
  logic [W:0]   full_sum;
  logic [W-1:0] low_sum;
  logic [NIB:0] nib_sum;
  logic         c_top, c_msb, ovf, zro, sgn, par, aux;
  logic [5:0]   st_n;
  logic [1:0]   cc_n;

  assign b_eff    = sub_i ? ~b_i : b_i;
  assign ci       = sub_i | carry_i;
  assign full_sum = {1'b0, a_i} + {1'b0, b_eff} + (W+1)'(ci);
  assign low_sum  = {1'b0, a_i[W-2:0]} + {1'b0, b_eff[W-2:0]} + W'(ci);
  assign nib_sum  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + (NIB+1)'(ci);

  assign c_top = full_sum[W];
  assign c_msb = low_sum[W-1];
  assign ovf   = c_top ^ c_msb;
  assign zro   = (full_sum[W-1:0] == '0);
  assign sgn   = full_sum[W-1];
  assign par   = ~^full_sum[W-1:0];
  assign aux   = nib_sum[NIB];
  assign st_n  = {ovf, sgn, zro, aux, par, c_top};

  always_comb begin
    if (ovf)      cc_n = 2'b11;
    else if (zro) cc_n = 2'b00;
    else if (sgn) cc_n = 2'b01;
    else          cc_n = 2'b10;
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          res_o <= '0;
          st_o  <= ST_RST;
          cc_o  <= 2'b00;
        end else begin
          res_o <= full_sum[W-1:0];
          st_o  <= st_n;
          cc_o  <= cc_n;
        end
      end
    end else begin : g_comb
      assign res_o = full_sum[W-1:0];
      assign st_o  = st_n;
      assign cc_o  = cc_n;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       freg_o <= '0;
    else if (wr_en_i) freg_o <= wr_data_i;
    else if (ld_en_i) freg_o <= {freg_o[7:6], st_n};
  end

  // R8
  cc_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_o == 2'b11) == st_o[5]);
  // R8
  cc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_o == 2'b00) |-> (st_o[3] && !st_o[5]));
  // R7
  zero_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_o[3] == (res_o == '0));
  // R5
  sign_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_o[4] == res_o[W-1]);
  // R11
  direct_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (freg_o == $past(wr_data_i)));
  // R10
  ctl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en_i && !wr_en_i) |=> (freg_o[7:6] == $past(freg_o[7:6])));
  // R10
  freg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en_i && !wr_en_i) |=> $stable(freg_o));
endmodule

// File: tb/arith_flag_gen_tb.sv
module arith_flag_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a_i = '0, b_i = '0, wr_data_i = '0;
  logic       carry_i = 1'b0, sub_i = 1'b0, ld_en_i = 1'b0, wr_en_i = 1'b0;
  logic [7:0] res_o, freg_o;
  logic [5:0] st_o;
  logic [1:0] cc_o;

  arith_flag_gen dut_i (
    .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .carry_i(carry_i),
    .sub_i(sub_i), .ld_en_i(ld_en_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .res_o(res_o), .st_o(st_o), .cc_o(cc_o), .freg_o(freg_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [7:0] res;
    logic [5:0] st;
    logic [1:0] cc;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  logic due = 1'b0;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  function automatic exp_t model(input int a, input int b, input int cin, input int sub);
    exp_t e;
    int bb, ci, sum, sa, sb, sr, ones;
    bit c, p, ac, z, s, v;
    bb  = sub ? (255 - b) : b;
    ci  = sub ? 1 : cin;
    sum = a + bb + ci;
    c   = (sum > 255);
    ac  = (((a % 16) + (bb % 16) + ci) > 15);
    sa  = (a > 127) ? a - 256 : a;
    sb  = (b > 127) ? b - 256 : b;
    sr  = sub ? (sa - sb) : (sa + sb + cin);
    v   = (sr > 127) || (sr < -128);
    e.res = 8'(sum % 256);
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(e.res[i]);
    p = (ones % 2 == 0);
    z = (e.res == 8'h00);
    s = e.res[7];
    e.st = {v, s, z, ac, p, c};
    if (v)      e.cc = 2'b11;
    else if (z) e.cc = 2'b00;
    else if (s) e.cc = 2'b01;
    else        e.cc = 2'b10;
    return e;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input int a, input int b, input int cin, input int sub,
                       input bit ld = 0, input bit wr = 0, input int wd = 0);
    @(negedge clk);
    a_i = 8'(a); b_i = 8'(b); carry_i = cin[0]; sub_i = sub[0];
    ld_en_i = ld; wr_en_i = wr; wr_data_i = 8'(wd);
    q.push_back(model(a, b, cin, sub));
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      cur <= q.pop_front();
      due <= 1'b1;
    end else begin
      due <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (due && !done) begin
      #1;
      chk("R1/R2 result (R9 one-edge latency)", res_o, cur.res);
      chk("R1/R2 carry", st_o[0], cur.st[0]);
      chk("R3 nibble carry", st_o[2], cur.st[2]);
      chk("R4 overflow", st_o[5], cur.st[5]);
      chk("R5 sign", st_o[4], cur.st[4]);
      chk("R6 parity", st_o[1], cur.st[1]);
      chk("R7 zero", st_o[3], cur.st[3]);
      chk("R8 condition code", cc_o, cur.cc);
    end
  end

  initial begin
    repeat (CLK_PERIOD * 2000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    exp_t e;
    logic [7:0] lf;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset res", res_o, 0);
    chk("R12 reset status", st_o, 6'b001010);
    chk("R12 reset cc", cc_o, 0);
    chk("R12 reset freg", freg_o, 0);
    @(negedge clk);
    rst_n = 1'b1;

    drive(8'h12, 8'h34, 0, 0);
    #1 chk("R9 output not yet updated", res_o, 0);
    drive(8'hFF, 8'h01, 0, 0);
    drive(8'h7F, 8'h01, 0, 0);
    drive(8'h80, 8'h80, 0, 0);
    drive(8'h0F, 8'h00, 1, 0);
    drive(8'hC0, 8'h3F, 1, 0);
    drive(8'h03, 8'h00, 0, 0);
    drive(8'h50, 8'h10, 0, 1);
    drive(8'h50, 8'h10, 1, 1);
    drive(8'h10, 8'h20, 0, 1);
    drive(8'h80, 8'h01, 0, 1);
    drive(8'h05, 8'h05, 1, 1);
    drive(8'h7F, 8'hFF, 0, 1);
    lf = 8'h5A;
    for (int i = 0; i < 24; i++) begin
      int x, y;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      x = lf;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      y = lf;
      drive(x, y, i % 2, (i / 2) % 2);
    end

    drive(8'h01, 8'h01, 0, 0, 0, 1, 8'hC5);
    drive(8'h01, 8'h01, 0, 0);
    #1 chk("R11 direct write", freg_o, 8'hC5);
    drive(8'h7F, 8'h01, 0, 0, 1, 0, 0);
    e = model(8'h7F, 8'h01, 0, 0);
    drive(8'h00, 8'h00, 0, 0);
    #1 chk("R10 load keeps control bits", freg_o, {2'b11, e.st});
    drive(8'h33, 8'h44, 1, 1);
    drive(8'hF0, 8'h0F, 0, 0);
    #1 chk("R10 hold without enables", freg_o, {2'b11, e.st});
    drive(8'h7F, 8'h01, 0, 0, 1, 1, 8'h00);
    drive(8'h00, 8'h00, 0, 0);
    #1 chk("R11 write outranks load", freg_o, 0);
    drive(8'h80, 8'h01, 0, 1, 1, 0, 0);
    e = model(8'h80, 8'h01, 0, 1);
    drive(8'h00, 8'h00, 0, 0);
    #1 chk("R10 load from subtraction", freg_o, {2'b00, e.st});

    repeat (4) @(negedge clk);
    #2;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule